// File: doc/BRIEF.md
# Digital Potentiometer Register Access Controller

This block is the register back end that sits behind a two-wire serial slave front end for a four-wiper digital potentiometer. The front end turns line activity into three single-cycle events: a start condition, a received byte, and a stop condition. For every received byte the block gives back an acknowledge decision one clock later. It checks the device address byte against the strapped hardware address and decodes the register address byte. It then applies the data byte to the wiper counter registers, to the status register, or to a 4x4 array of data registers that models the nonvolatile store.

The status register holds a nonvolatile-enable flag and a row select. When software writes it with the enable flag set, all four wipers reload from the chosen row at the moment that byte is acknowledged. A wiper write either stays volatile or goes through to the data register of the selected row. In the second case the whole row is copied into the wipers, and a timed busy period starts at the stop condition. While that period runs, the block refuses every byte and ignores every start.

Top module: `dpot_reg_ctrl`

## Requirements
- R1: After reset all four wipers read 0, busy_o is low and ack_valid_o is low; the status register and every data register are 0.
- R2: After a start, the first byte is acknowledged only if it equals {4'b0101, hw_addr_i[2:0], 1'b0}. Any other value, including one with bit 0 set, is refused, and every further byte is refused until the next start.
- R3: The second byte is acknowledged only if bits 7:3 are 0 and bits 2:0 are 0..3 (wiper slot 0..3) or 7 (status). Any other value is refused, and the rest of the transaction is refused.
- R4: Every byte_valid_i pulse gives a single-cycle ack_valid_o pulse on the following clock, with ack_o set to 1 for acknowledge and 0 for refuse. ack_valid_o stays low when no byte was presented.
- R5: A data byte to address 7 stores bits 2:0 into the status register: bit 0 is the nonvolatile enable and bits 2:1 are the row. If bit 0 of the byte is 1, every wiper loads the data register of that new row in the same clock that the acknowledge appears.
- R6: A data byte to wiper slot k, with the status enable at 0 or wp_i low, changes only wiper k, and no data register changes.
- R7: A data byte to wiper slot k, with the status enable at 1 and wp_i high, writes data register [row][k], and all wipers load row [row]. Wiper k therefore holds the new byte.
- R8: busy_o rises on the clock of the stop that ends a transaction containing an R7 write, and stays high for exactly NV_CYCLES clocks. Volatile and status writes never raise busy_o.
- R9: While busy_o is high every byte is refused, starts and stops are ignored, and no wiper changes.
- R10: After the data byte, any further byte in the same transaction is refused and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hw_addr_i | input | 3 | Strapped hardware address |
| wp_i | input | 1 | Write protect; high allows nonvolatile writes |
| start_i | input | 1 | Start condition event |
| byte_valid_i | input | 1 | Received-byte event |
| byte_i | input | 8 | Received byte |
| stop_i | input | 1 | Stop condition event |
| ack_valid_o | output | 1 | Acknowledge decision valid |
| ack_o | output | 1 | 1 = acknowledge, 0 = refuse |
| busy_o | output | 1 | Nonvolatile write cycle in progress |
| wiper_o | output | 32 | Wiper slots 0..3, slot k at bits 8k+7:8k |

## Verification
The bench targets several corner cases:
- A status write with the enable bit set must reload wipers from the row in the byte, not from the old status value. A design that used the stale row would load zeros where the bench expects stored data.
- A write through to a data register must replace only the addressed entry of the copied row. An off-by-one there leaves a neighbour wiper wrong.
- Pulling write protect low with the enable set must leave the data array untouched. A later row reload then exposes any leak.
- The busy window is measured to the exact clock.
- Start, address and data bytes are sent during the busy window. A design that still listened would acknowledge them or change wipers.

Wrong device IDs, a set read bit, unused addresses, nonzero upper address bits and a surplus data byte must all be refused without side effects.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned HW_W   = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_REG, ST_DATA, ST_DONE, ST_SKIP
  } bus_st_e;

  typedef enum logic [1:0] {
    TGT_NONE, TGT_WIPER, TGT_STATUS
  } tgt_e;
endpackage

// File: rtl/dpot_addr_decode.sv
module dpot_addr_decode
  import dpot_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned WIPERS      = 4,
  parameter int unsigned STATUS_ADDR = 7,
  parameter logic [3:0]  DEV_ID      = 4'b0101,
  localparam int unsigned IDX_W      = $clog2(WIPERS)
) (
  input  logic [DW-1:0]    byte_i,
  input  logic [HW_W-1:0]  hw_addr_i,
  output logic             dev_hit_o,
  output tgt_e             tgt_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [ADDR_W-1:0] reg_a;
  logic              hi_zero;

  assign reg_a   = byte_i[ADDR_W-1:0];
  assign hi_zero = (byte_i[DW-1:ADDR_W] == '0);
  // write direction bit must be 0
  assign dev_hit_o = (byte_i == DW'({DEV_ID, hw_addr_i, 1'b0}));
  assign idx_o     = reg_a[IDX_W-1:0];

  always_comb begin
    tgt_o = TGT_NONE;
    if (hi_zero) begin
      if (reg_a == ADDR_W'(STATUS_ADDR))
        tgt_o = TGT_STATUS;
      else if ({1'b0, reg_a} < (ADDR_W + 1)'(WIPERS))
        tgt_o = TGT_WIPER;
    end
  end
endmodule

// File: rtl/dpot_nv_timer.sv
module dpot_nv_timer #(
  parameter int unsigned NV_CYCLES = 16,
  localparam int unsigned CNT_W    = $clog2(NV_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic busy_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (kick_i)         cnt_q <= CNT_W'(NV_CYCLES);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/dpot_reg_file.sv
module dpot_reg_file #(
  parameter int unsigned WIPERS = 4,
  parameter int unsigned ROWS   = 4,
  parameter int unsigned DW     = 8,
  localparam int unsigned IDX_W = $clog2(WIPERS),
  localparam int unsigned ROW_W = $clog2(ROWS),
  localparam int unsigned SR_W  = ROW_W + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sr_we_i,
  input  logic [SR_W-1:0]      sr_d_i,
  input  logic                 wip_we_i,
  input  logic                 nv_we_i,
  input  logic                 row_load_i,
  input  logic [ROW_W-1:0]     row_sel_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [DW-1:0]        d_i,
  output logic [SR_W-1:0]      sr_o,
  output logic [WIPERS*DW-1:0] wiper_o
);
  logic [DW-1:0] dr_q  [ROWS][WIPERS];
  logic [DW-1:0] wip_q [WIPERS];
  logic [SR_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (sr_we_i) sr_q <= sr_d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < ROWS; r++)
        for (int w = 0; w < WIPERS; w++)
          dr_q[r][w] <= '0;
    end else if (nv_we_i) begin
      dr_q[row_sel_i][idx_i] <= d_i;
    end
  end

  // row copy uses old array contents, addressed slot takes the new byte
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < WIPERS; w++) wip_q[w] <= '0;
    end else begin
      for (int w = 0; w < WIPERS; w++) begin
        if (nv_we_i && idx_i == IDX_W'(w))
          wip_q[w] <= d_i;
        else if (nv_we_i || row_load_i)
          wip_q[w] <= dr_q[row_sel_i][w];
        else if (wip_we_i && idx_i == IDX_W'(w))
          wip_q[w] <= d_i;
      end
    end
  end

  for (genvar g = 0; g < WIPERS; g++) begin : g_out
    assign wiper_o[g*DW +: DW] = wip_q[g];
  end

  assign sr_o = sr_q;
endmodule

// File: rtl/dpot_reg_ctrl.sv
module dpot_reg_ctrl
  import dpot_pkg::*;
#(
  parameter int unsigned WIPERS      = 4,
  parameter int unsigned ROWS        = 4,
  parameter int unsigned DW          = 8,
  parameter int unsigned NV_CYCLES   = 16,
  parameter int unsigned STATUS_ADDR = 7,
  parameter logic [3:0]  DEV_ID      = 4'b0101
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [2:0]           hw_addr_i,
  input  logic                 wp_i,
  input  logic                 start_i,
  input  logic                 byte_valid_i,
  input  logic [DW-1:0]        byte_i,
  input  logic                 stop_i,
  output logic                 ack_valid_o,
  output logic                 ack_o,
  output logic                 busy_o,
  output logic [WIPERS*DW-1:0] wiper_o
);
  localparam int unsigned IDX_W = $clog2(WIPERS);
  localparam int unsigned ROW_W = $clog2(ROWS);
  localparam int unsigned SR_W  = ROW_W + 1;

  bus_st_e          st_q;
  tgt_e             tgt_q, dec_tgt;
  logic [IDX_W-1:0] idx_q, dec_idx;
  logic             dev_hit;
  logic             pend_q;
  logic             ack_v_q, ack_q;

  logic [SR_W-1:0]  sr;
  logic             sr_we, wip_we, nv_we, row_load;
  logic [ROW_W-1:0] row_sel;
  logic             data_evt, kick;

  dpot_addr_decode #(
    .DW(DW), .WIPERS(WIPERS), .STATUS_ADDR(STATUS_ADDR), .DEV_ID(DEV_ID)
  ) u_dec (
    .byte_i    (byte_i),
    .hw_addr_i (hw_addr_i),
    .dev_hit_o (dev_hit),
    .tgt_o     (dec_tgt),
    .idx_o     (dec_idx)
  );

  dpot_nv_timer #(.NV_CYCLES(NV_CYCLES)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .kick_i (kick),
    .busy_o (busy_o)
  );

  assign data_evt = byte_valid_i && !busy_o && !start_i && !stop_i && (st_q == ST_DATA);
  assign kick     = stop_i && !busy_o && !start_i && pend_q;

  always_comb begin
    sr_we    = 1'b0;
    wip_we   = 1'b0;
    nv_we    = 1'b0;
    row_load = 1'b0;
    row_sel  = sr[SR_W-1:1];
    if (data_evt) begin
      if (tgt_q == TGT_STATUS) begin
        sr_we    = 1'b1;
        row_load = byte_i[0];
        row_sel  = byte_i[SR_W-1:1];
      end else if (tgt_q == TGT_WIPER) begin
        if (sr[0] && wp_i) nv_we  = 1'b1;
        else               wip_we = 1'b1;
      end
    end
  end

  dpot_reg_file #(.WIPERS(WIPERS), .ROWS(ROWS), .DW(DW)) u_rf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sr_we_i    (sr_we),
    .sr_d_i     (byte_i[SR_W-1:0]),
    .wip_we_i   (wip_we),
    .nv_we_i    (nv_we),
    .row_load_i (row_load),
    .row_sel_i  (row_sel),
    .idx_i      (idx_q),
    .d_i        (byte_i),
    .sr_o       (sr),
    .wiper_o    (wiper_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      tgt_q   <= TGT_NONE;
      idx_q   <= '0;
      pend_q  <= 1'b0;
      ack_v_q <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      ack_v_q <= byte_valid_i;
      ack_q   <= 1'b0;
      if (busy_o) begin
        st_q   <= ST_IDLE;
        pend_q <= 1'b0;
      end else if (start_i) begin
        st_q   <= ST_DEV;
        pend_q <= 1'b0;
      end else if (stop_i) begin
        st_q   <= ST_IDLE;
        pend_q <= 1'b0;
      end else if (byte_valid_i) begin
        unique case (st_q)
          ST_DEV: begin
            ack_q <= dev_hit;
            st_q  <= dev_hit ? ST_REG : ST_SKIP;
          end
          ST_REG: begin
            if (dec_tgt != TGT_NONE) begin
              ack_q <= 1'b1;
              tgt_q <= dec_tgt;
              idx_q <= dec_idx;
              st_q  <= ST_DATA;
            end else begin
              st_q  <= ST_SKIP;
            end
          end
          ST_DATA: begin
            ack_q  <= 1'b1;
            pend_q <= nv_we;
            st_q   <= ST_DONE;
          end
          default: st_q <= st_q;
        endcase
      end
    end
  end

  assign ack_valid_o = ack_v_q;
  assign ack_o       = ack_q;
endmodule

// File: rtl/dpot_reg_ctrl_chk.sv
module dpot_reg_ctrl_chk #(
  parameter int unsigned WIPERS    = 4,
  parameter int unsigned DW        = 8,
  parameter int unsigned NV_CYCLES = 16,
  localparam int unsigned RUN_W    = $clog2(NV_CYCLES + 2)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 byte_valid_i,
  input logic                 stop_i,
  input logic                 ack_valid_o,
  input logic                 ack_o,
  input logic                 busy_o,
  input logic [WIPERS*DW-1:0] wiper_o
);
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_o) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  assert_ack_follow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_i |=> ack_valid_o);
  assert_ack_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_valid_i |=> !ack_valid_o);
  assert_ack_gated_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> ack_valid_o);
  assert_busy_nack_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && byte_valid_i) |=> !ack_o);
  assert_busy_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(wiper_o));
  assert_busy_from_stop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(stop_i));
  assert_busy_max_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (run_q < RUN_W'(NV_CYCLES)));
  assert_busy_len_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (run_q == RUN_W'(NV_CYCLES)));
endmodule

bind dpot_reg_ctrl dpot_reg_ctrl_chk #(
  .WIPERS(WIPERS), .DW(DW), .NV_CYCLES(NV_CYCLES)
) u_chk (.*);

// File: tb/tb_dpot_reg_ctrl.sv
module tb_dpot_reg_ctrl;
  localparam int NV = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] hw = 3'b101;
  logic       wp = 1'b0;
  logic       start = 1'b0, bv = 1'b0, stop = 1'b0;
  logic [7:0] bd = 8'h00;
  logic       ack_v, ack, busy;
  logic [31:0] wip;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  int m_st, m_addr, m_sr, m_pend, m_busy, m_left, m_ackv, m_ack;
  int m_w[4];
  int m_dr[16];

  always #10 clk = ~clk;

  dpot_reg_ctrl #(.NV_CYCLES(NV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .hw_addr_i(hw), .wp_i(wp),
    .start_i(start), .byte_valid_i(bv), .byte_i(bd), .stop_i(stop),
    .ack_valid_o(ack_v), .ack_o(ack), .busy_o(busy), .wiper_o(wip)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model; st: 0 idle,1 dev,2 reg,3 data,4 done,5 skip
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_addr = 0; m_sr = 0; m_pend = 0; m_busy = 0; m_left = 0;
      m_ackv = 0; m_ack = 0;
      foreach (m_w[i]) m_w[i] = 0;
      foreach (m_dr[i]) m_dr[i] = 0;
    end else begin
      m_ackv = bv; m_ack = 0;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) m_busy = 0;
        m_st = 0; m_pend = 0;
      end else if (start) begin
        m_st = 1; m_pend = 0;
      end else if (stop) begin
        if (m_pend) begin m_busy = 1; m_left = NV; end
        m_st = 0; m_pend = 0;
      end else if (bv) begin
        int b;
        b = bd;
        case (m_st)
          1: if (b == (8'h50 | (hw << 1))) begin m_ack = 1; m_st = 2; end else m_st = 5;
          2: if (b < 4 || b == 7) begin m_ack = 1; m_addr = b; m_st = 3; end else m_st = 5;
          3: begin
            m_ack = 1; m_st = 4;
            if (m_addr == 7) begin
              m_sr = b & 7;
              if (b & 1) for (int w = 0; w < 4; w++) m_w[w] = m_dr[((b >> 1) & 3) * 4 + w];
            end else if ((m_sr & 1) && wp) begin
              m_dr[(m_sr >> 1) * 4 + m_addr] = b;
              for (int w = 0; w < 4; w++) m_w[w] = m_dr[(m_sr >> 1) * 4 + w];
              m_pend = 1;
            end else begin
              m_w[m_addr] = b;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(ack_v == m_ackv[0], "R4 ack_valid", ack_v, m_ackv);
      if (m_ackv) chk(ack == m_ack[0], "R2/R3/R9/R10 ack", ack, m_ack);
      chk(busy == m_busy[0], "R8 busy", busy, m_busy);
      for (int w = 0; w < 4; w++)
        chk(wip[w*8 +: 8] == m_w[w][7:0], "R5/R6/R7 wiper", wip[w*8 +: 8], m_w[w]);
    end
  end

  task automatic do_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input bit exp, input string tag);
    @(negedge clk); bv = 1'b1; bd = b;
    @(negedge clk); bv = 1'b0;
    chk(ack_v && ack == exp, tag, {ack_v, ack}, {1'b1, exp});
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input string tag);
    do_start();
    send({4'b0101, hw, 1'b0}, 1'b1, tag);
    send(a, 1'b1, tag);
    send(d, 1'b1, tag);
    do_stop();
  endtask

  function automatic logic [7:0] wv(input int k);
    return wip[k*8 +: 8];
  endfunction

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(wip == 32'h0, "R1 wipers", wip, 0);
    chk(!busy, "R1 busy", busy, 0);
    chk(!ack_v, "R1 ack_valid", ack_v, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 volatile write, slot 2
    wr(8'h02, 8'h3A, "R6 volatile write");
    chk(wv(2) == 8'h3A, "R6 slot2", wv(2), 8'h3A);
    chk(wv(0) == 0 && wv(1) == 0 && wv(3) == 0, "R6 others", wip, 32'h003A0000);
    chk(!busy, "R8 no busy on volatile", busy, 0);

    // R2 device mismatch and read bit
    do_start();
    send(8'h50, 1'b0, "R2 wrong hw addr");
    send(8'h01, 1'b0, "R2 skip reg");
    send(8'h55, 1'b0, "R2 skip data");
    do_stop();
    do_start();
    send({4'b0101, hw, 1'b1}, 1'b0, "R2 read bit");
    do_stop();
    chk(wv(1) == 0, "R2 no effect", wv(1), 0);

    // R3 bad register addresses
    do_start();
    send({4'b0101, hw, 1'b0}, 1'b1, "R3 dev");
    send(8'h05, 1'b0, "R3 unused addr");
    send(8'h44, 1'b0, "R3 skipped data");
    do_stop();
    do_start();
    send({4'b0101, hw, 1'b0}, 1'b1, "R3 dev");
    send(8'h09, 1'b0, "R3 upper bits");
    do_stop();
    chk(wv(1) == 0 && wv(2) == 8'h3A, "R3 no effect", wip, 32'h003A0000);

    // R5 status write with enable: row 1 is empty
    wp = 1'b1;
    wr(8'h07, 8'h03, "R5 status");
    chk(wip == 32'h0, "R5 row1 reload", wip, 0);

    // R7 nonvolatile write slot 1, R8 busy length
    do_start();
    send({4'b0101, hw, 1'b0}, 1'b1, "R7 dev");
    send(8'h01, 1'b1, "R7 reg");
    send(8'h55, 1'b1, "R7 data");
    chk(wv(1) == 8'h55, "R7 slot1", wv(1), 8'h55);
    // R10 surplus byte
    send(8'h66, 1'b0, "R10 extra byte");
    chk(wv(1) == 8'h55, "R10 no effect", wv(1), 8'h55);
    chk(!busy, "R8 not busy before stop", busy, 0);
    do_stop();
    n = 0;
    while (busy && n < 100) begin n++; @(negedge clk); end
    chk(n == NV, "R8 busy length", n, NV);

    // second NV write, then R9 traffic during busy
    wr(8'h03, 8'h77, "R7 slot3");
    chk(busy, "R8 busy", busy, 1);
    do_start();
    send({4'b0101, hw, 1'b0}, 1'b0, "R9 dev during busy");
    send(8'h00, 1'b0, "R9 reg during busy");
    send(8'h99, 1'b0, "R9 data during busy");
    chk(wip == 32'h77005500, "R9 wipers held", wip, 32'h77005500);
    while (busy) @(negedge clk);
    send(8'h00, 1'b0, "R9 start was ignored");

    // R5 reload other rows
    wr(8'h07, 8'h05, "R5 row2");
    chk(wip == 32'h0, "R5 row2 empty", wip, 0);
    wr(8'h07, 8'h03, "R5 row1");
    chk(wip == 32'h77005500, "R5 row1 restore", wip, 32'h77005500);

    // R6 enable set but write protect low
    wp = 1'b0;
    wr(8'h00, 8'h11, "R6 protected");
    chk(wv(0) == 8'h11, "R6 slot0", wv(0), 8'h11);
    chk(!busy, "R6 no busy", busy, 0);
    wr(8'h07, 8'h03, "R6 reload");
    chk(wv(0) == 8'h00, "R6 array untouched", wv(0), 0);

    // R5 status write without enable: no reload
    wr(8'h02, 8'hC3, "R5 vol");
    wr(8'h07, 8'h02, "R5 no enable");
    chk(wv(2) == 8'hC3, "R5 no reload", wv(2), 8'hC3);

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule